// File: doc/BRIEF.md
# Tone Guard-Time Steering

This block replaces the resistor-capacitor steering network that follows a dual-tone detector. The detector supplies an early-steering level, which is high while it believes a valid tone pair is present, together with a 4-bit decoded tone code. The block lets a tone count only after the early-steering level has stayed high for a programmable number of clock cycles. An accepted tone is held until the level has stayed low for a second programmable number of cycles. The two guard lengths are separate run-time inputs, so short bursts and short dropouts are filtered on their own terms.

When a tone is accepted, the decoded code is written into a receive register. A receive-full flag is set, and a one-cycle latch strobe is produced along with an optional one-cycle interrupt pulse. The steering level is brought out as the delayed-steering status. While call-progress mode is selected, the steering logic is held idle and no tone is accepted. A read strobe from the host side clears the receive-full flag.

Top module: `tone_steer`

## Requirements
- R1: After reset, `steer_o`, `rx_full_o`, `latch_o` and `irq_o` are 0 and `rx_code_o` is 4'h0.
- R2: With `steer_o` low and call-progress mode off, `steer_o` rises after the clock edge at which `est_i` has been sampled high on `present_cycles_i` consecutive edges. A value of 0 acts as 1.
- R3: A burst of `est_i` that is high on fewer consecutive edges than the tone-present guard produces no steering, no latch strobe and no change of `rx_full_o` or `rx_code_o`.
- R4: While `steer_o` is high, it stays high as long as `est_i` is high. It falls after the edge at which `est_i` has been sampled low on `absent_cycles_i` consecutive edges. A value of 0 acts as 1.
- R5: A dropout of `est_i` shorter than the tone-absent guard leaves `steer_o` high and produces no second latch strobe for the same digit.
- R6: At the edge where `steer_o` rises, `code_i` is captured into `rx_code_o`, and `latch_o` is high for exactly the first cycle in which `steer_o` is high. `rx_code_o` does not change at any other time.
- R7: `rx_full_o` is set by an acceptance and cleared by `rd_i` sampled high at an edge. When both happen at the same edge, the flag ends up set.
- R8: `irq_o` is high exactly in the cycles where `latch_o` is high and `irq_en_i` was high at the accepting edge.
- R9: When `cp_mode_i` is sampled high, `steer_o` is low after that edge, both guard runs restart, and no acceptance occurs while it stays high.
- R10: The tone-present and tone-absent guard lengths act independently. Either may be changed between tones without affecting the other.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| est_i | input | 1 | Early-steering level from the detector |
| code_i | input | CODE_W | Decoded tone code from the detector |
| present_cycles_i | input | CNT_W | Tone-present guard length in cycles |
| absent_cycles_i | input | CNT_W | Tone-absent guard length in cycles |
| cp_mode_i | input | 1 | Call-progress mode select; blocks acceptance |
| rd_i | input | 1 | Receive register read strobe; clears the full flag |
| irq_en_i | input | 1 | Interrupt enable |
| steer_o | output | 1 | Delayed-steering status |
| rx_code_o | output | CODE_W | Receive register holding the last accepted code |
| rx_full_o | output | 1 | Receive register holds an unread code |
| latch_o | output | 1 | One-cycle strobe on acceptance |
| irq_o | output | 1 | One-cycle interrupt pulse on acceptance |

## Verification
Every result of this block is registered once. Steering, the latch strobe, the interrupt pulse and the captured code are therefore all visible in the cycle after the edge that completes the tone-present run. The steering fall follows the edge that completes the tone-absent run, and the clearing by a read follows the edge that samples `rd_i`. The bench drives inputs at the falling edge and lets one rising edge pass. At the next falling edge it compares every output against a run-length model that is updated once per rising edge. The directed cases count exact edges around each guard boundary, with runs of one cycle fewer and exactly the guard length.

// File: rtl/tsg_pkg.sv
// Package: shared types for the tone guard-time steering block.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package tsg_pkg;

    // Steering state: idle (no tone accepted) or steered (tone held).
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_STEER = 1'b1
    } steer_state_e;

    // Indices of the two guard timers inside the top module.
    localparam int TMR_PRESENT = 0;
    localparam int TMR_ABSENT  = 1;
    localparam int NUM_TMR     = 2;

endpackage

// File: rtl/tsg_guard_timer.sv
// Module: tsg_guard_timer
// Counts consecutive cycles in which run_i is high. done_o is asserted in the
// cycle whose edge completes limit_i consecutive runs. The run restarts after
// done or whenever run_i drops. A limit of zero is treated as one.
// Assumes: limit_i is stable while a run is in progress.
module tsg_guard_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] next_w;
    logic [EXT_W-1:0] lim_w;

    // Effective limit with zero raised to one; next run length if counted now.
    always_comb begin
        lim_w  = (limit_i == '0) ? EXT_W'(1) : {1'b0, limit_i};
        next_w = {1'b0, cnt_q} + EXT_W'(1);
        done_o = run_i && (next_w >= lim_w);
    end

    // Run-length counter: restarts on a break in the run or on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || done_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= next_w[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/tsg_steer_fsm.sv
// Module: tsg_steer_fsm
// Two-state steering controller. In idle it asks the present timer to run
// while early steering is high. In steer it asks the absent timer to run
// while early steering is low. Call-progress mode forces idle and stops both
// timers.
// Assumes: the done inputs come from timers fed by the run outputs here.
module tsg_steer_fsm
    import tsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic est_i,
    input  logic cp_mode_i,
    input  logic present_done_i,
    input  logic absent_done_i,
    output logic run_present_o,
    output logic run_absent_o,
    output logic accept_o,
    output logic steer_o
);

    steer_state_e state_q;
    steer_state_e state_d;

    // Timer requests depend on the current state and the detector level.
    always_comb begin
        run_present_o = (state_q == ST_IDLE)  &&  est_i && !cp_mode_i;
        run_absent_o  = (state_q == ST_STEER) && !est_i && !cp_mode_i;
        accept_o      = (state_q == ST_IDLE)  && present_done_i;
    end

    // Next-state selection; call-progress mode overrides everything.
    always_comb begin
        state_d = state_q;
        if (cp_mode_i) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (present_done_i) state_d = ST_STEER;
                ST_STEER: if (absent_done_i)  state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign steer_o = (state_q == ST_STEER);

endmodule

// File: rtl/tsg_rx_latch.sv
// Module: tsg_rx_latch
// Receive register for accepted tone codes. On accept_i it captures code_i,
// sets the full flag and emits one-cycle latch and interrupt pulses. A read
// strobe clears the full flag; an acceptance at the same edge wins.
// Assumes: accept_i is a single-cycle pulse.
module tsg_rx_latch #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              rd_i,
    input  logic              irq_en_i,
    output logic [CODE_W-1:0] code_o,
    output logic              full_o,
    output logic              latch_o,
    output logic              irq_o
);

    // Code capture: only an acceptance writes the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
        end else if (accept_i) begin
            code_o <= code_i;
        end
    end

    // Full flag: set by acceptance, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_o <= 1'b0;
        end else if (accept_i) begin
            full_o <= 1'b1;
        end else if (rd_i) begin
            full_o <= 1'b0;
        end
    end

    // Event pulses: one cycle long, aligned with the new register contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_o <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            latch_o <= accept_i;
            irq_o   <= accept_i && irq_en_i;
        end
    end

endmodule

// File: rtl/tone_steer.sv
// Module: tone_steer (top)
// Digital guard-time steering for a dual-tone receiver. It filters the
// detector's early-steering level with independent tone-present and
// tone-absent guard lengths, latches the decoded code on acceptance, and
// blocks acceptance in call-progress mode.
// Assumes: code_i is valid whenever est_i is high; guard lengths change
// only while no tone is being timed.
module tone_steer
    import tsg_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              est_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CNT_W-1:0]  present_cycles_i,
    input  logic [CNT_W-1:0]  absent_cycles_i,
    input  logic              cp_mode_i,
    input  logic              rd_i,
    input  logic              irq_en_i,
    output logic              steer_o,
    output logic [CODE_W-1:0] rx_code_o,
    output logic              rx_full_o,
    output logic              latch_o,
    output logic              irq_o
);

    logic [NUM_TMR-1:0] tmr_run;
    logic [NUM_TMR-1:0] tmr_done;
    logic [CNT_W-1:0]   tmr_limit [NUM_TMR];
    logic               accept;

    // Route each guard length to its timer.
    always_comb begin
        tmr_limit[TMR_PRESENT] = present_cycles_i;
        tmr_limit[TMR_ABSENT]  = absent_cycles_i;
    end

    // One run-length timer per guard interval.
    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        tsg_guard_timer #(
            .CNT_W (CNT_W)
        ) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_i   (tmr_run[g]),
            .limit_i (tmr_limit[g]),
            .done_o  (tmr_done[g])
        );
    end

    tsg_steer_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .est_i          (est_i),
        .cp_mode_i      (cp_mode_i),
        .present_done_i (tmr_done[TMR_PRESENT]),
        .absent_done_i  (tmr_done[TMR_ABSENT]),
        .run_present_o  (tmr_run[TMR_PRESENT]),
        .run_absent_o   (tmr_run[TMR_ABSENT]),
        .accept_o       (accept),
        .steer_o        (steer_o)
    );

    tsg_rx_latch #(
        .CODE_W (CODE_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .code_i   (code_i),
        .rd_i     (rd_i),
        .irq_en_i (irq_en_i),
        .code_o   (rx_code_o),
        .full_o   (rx_full_o),
        .latch_o  (latch_o),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/tone_steer_checker.sv
// Module: tone_steer_checker
// Port-level properties of tone_steer, attached with bind.
// Assumes: synchronous active-low reset on rst_n.
module tone_steer_checker #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              est_i,
    input logic              cp_mode_i,
    input logic              steer_o,
    input logic [CODE_W-1:0] rx_code_o,
    input logic              rx_full_o,
    input logic              latch_o,
    input logic              irq_o
);

    // R2: steering cannot rise while the detector reports no tone.
    assert_no_rise_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!steer_o && !est_i) |=> !steer_o);

    // R4: steering holds while the tone persists outside call-progress mode.
    assert_hold_tone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_o && est_i && !cp_mode_i) |=> steer_o);

    // R6: latch strobe appears exactly with the steering rise.
    assert_rise_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(steer_o) |-> latch_o);
    assert_latch_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |-> $rose(steer_o));

    // R6: the receive register changes only with a latch strobe.
    assert_code_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_o |-> $stable(rx_code_o));

    // R7: the full flag is set whenever a code has just been latched.
    assert_full_on_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |-> rx_full_o);

    // R8: an interrupt pulse only accompanies a latch strobe.
    assert_irq_with_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> latch_o);

    // R9: call-progress mode clears steering and blocks acceptance.
    assert_cp_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cp_mode_i |=> (!steer_o && !latch_o));

endmodule

bind tone_steer tone_steer_checker #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .est_i     (est_i),
    .cp_mode_i (cp_mode_i),
    .steer_o   (steer_o),
    .rx_code_o (rx_code_o),
    .rx_full_o (rx_full_o),
    .latch_o   (latch_o),
    .irq_o     (irq_o)
);

// File: tb/tone_steer_tb.sv
// Bench for tone_steer: directed guard-boundary cases plus seeded random
// bursts, compared each cycle against a run-length model.
module tone_steer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              est = 1'b0;
    logic [CODE_W-1:0] code = '0;
    logic [CNT_W-1:0]  pres_len = 16'd5;
    logic [CNT_W-1:0]  abs_len = 16'd4;
    logic              cp = 1'b0;
    logic              rd = 1'b0;
    logic              irq_en = 1'b0;
    logic              steer;
    logic [CODE_W-1:0] rx_code;
    logic              rx_full;
    logic              latch;
    logic              irq;

    int checks = 0;
    int failures = 0;
    int latch_seen = 0;

    // Model state after the most recent rising edge.
    int m_steer, m_run, m_code, m_full, m_latch, m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    tone_steer #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .est_i(est), .code_i(code),
        .present_cycles_i(pres_len), .absent_cycles_i(abs_len),
        .cp_mode_i(cp), .rd_i(rd), .irq_en_i(irq_en),
        .steer_o(steer), .rx_code_o(rx_code), .rx_full_o(rx_full),
        .latch_o(latch), .irq_o(irq)
    );

    function automatic int eff_len(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_steer = 0; m_run = 0; m_code = 0; m_full = 0; m_latch = 0; m_irq = 0;
    endtask

    // Model one rising edge with the inputs currently applied.
    task automatic model_edge();
        int acc = 0;
        m_latch = 0; m_irq = 0;
        if (cp) begin
            m_steer = 0; m_run = 0;
        end else if (m_steer == 0) begin
            if (est) begin
                m_run++;
                if (m_run >= eff_len(int'(pres_len))) begin m_steer = 1; m_run = 0; acc = 1; end
            end else m_run = 0;
        end else begin
            if (!est) begin
                m_run++;
                if (m_run >= eff_len(int'(abs_len))) begin m_steer = 0; m_run = 0; end
            end else m_run = 0;
        end
        if (acc != 0) begin
            m_code = int'(code); m_full = 1; m_latch = 1; m_irq = int'(irq_en);
        end else if (rd) m_full = 0;
    endtask

    // Apply inputs (at a falling edge), pass one rising edge, compare outputs.
    task automatic step(input logic e, input logic [CODE_W-1:0] c, input logic p,
                        input logic r, input logic ie);
        est = e; code = c; cp = p; rd = r; irq_en = ie;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (latch) latch_seen++;
        chk("R4", "steer", int'(steer), m_steer);
        chk("R6", "rx_code", int'(rx_code), m_code);
        chk("R6", "latch", int'(latch), m_latch);
        chk("R7", "rx_full", int'(rx_full), m_full);
        chk("R8", "irq", int'(irq), m_irq);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic tone(input int n, input logic [CODE_W-1:0] c, input logic ie);
        for (int i = 0; i < n; i++) step(1'b1, c, 1'b0, 1'b0, ie);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1", "steer", int'(steer), 0);
        chk("R1", "rx_full", int'(rx_full), 0);
        chk("R1", "rx_code", int'(rx_code), 0);
        chk("R1", "latch", int'(latch), 0);
        chk("R1", "irq", int'(irq), 0);

        // R3: present guard 5, burst of 4 edges is rejected.
        pres_len = 16'd5; abs_len = 16'd4;
        base = latch_seen;
        tone(4, 4'h7, 1'b1);
        idle(3);
        chk("R3", "latch count", latch_seen - base, 0);
        chk("R3", "rx_full", int'(rx_full), 0);
        chk("R3", "rx_code", int'(rx_code), 0);

        // R2: after 4 edges still low, after the 5th steering is high.
        tone(4, 4'h9, 1'b1);
        chk("R2", "steer before guard", int'(steer), 0);
        tone(1, 4'h9, 1'b1);
        chk("R2", "steer at guard", int'(steer), 1);
        chk("R6", "latched code", int'(rx_code), 9);
        chk("R8", "irq enabled", int'(irq), 1);

        // R5: dropout of 3 edges with absent guard 4 keeps the digit.
        base = latch_seen;
        idle(3);
        tone(3, 4'h9, 1'b1);
        chk("R5", "steer after dropout", int'(steer), 1);
        chk("R5", "second latch", latch_seen - base, 0);

        // R4: 3 low edges keep steering, the 4th clears it.
        idle(3);
        chk("R4", "steer before absent guard", int'(steer), 1);
        idle(1);
        chk("R4", "steer after absent guard", int'(steer), 0);

        // R7: read clears the flag; read at the accepting edge leaves it set.
        step(1'b0, 4'h0, 1'b0, 1'b1, 1'b0);
        chk("R7", "cleared by read", int'(rx_full), 0);
        tone(4, 4'h3, 1'b0);
        step(1'b1, 4'h3, 1'b0, 1'b1, 1'b0);
        chk("R7", "set wins over read", int'(rx_full), 1);
        chk("R8", "irq disabled", int'(irq), 0);
        idle(4);

        // R9: call-progress mode blocks acceptance and clears steering.
        base = latch_seen;
        for (int i = 0; i < 12; i++) step(1'b1, 4'hA, 1'b1, 1'b0, 1'b1);
        chk("R9", "steer in cp mode", int'(steer), 0);
        chk("R9", "latch in cp mode", latch_seen - base, 0);
        tone(5, 4'hB, 1'b0);
        chk("R9", "steer after cp", int'(steer), 1);
        step(1'b1, 4'hB, 1'b1, 1'b0, 1'b0);
        chk("R9", "cp drops steer", int'(steer), 0);
        idle(2);

        // R10: short present guard, long absent guard.
        pres_len = 16'd2; abs_len = 16'd9;
        tone(2, 4'hC, 1'b0);
        chk("R10", "fast rise", int'(steer), 1);
        idle(8);
        chk("R10", "long hold", int'(steer), 1);
        idle(1);
        chk("R10", "release", int'(steer), 0);

        // R2/R4: zero guard lengths act as one.
        pres_len = 16'd0; abs_len = 16'd0;
        tone(1, 4'hE, 1'b0);
        chk("R2", "zero present guard", int'(steer), 1);
        idle(1);
        chk("R4", "zero absent guard", int'(steer), 0);

        // Random bursts and gaps under two guard settings.
        for (int cfg = 0; cfg < 2; cfg++) begin
            pres_len = (cfg == 0) ? 16'd6 : 16'd3;
            abs_len  = (cfg == 0) ? 16'd4 : 16'd8;
            idle(int'(abs_len) + 1);
            for (int b = 0; b < 120; b++) begin
                logic [CODE_W-1:0] c = CODE_W'($urandom_range(0, 15));
                logic pc = ($urandom_range(0, 19) == 0);
                int blen = $urandom_range(1, 2 * int'(pres_len) + 2);
                int glen = $urandom_range(1, 2 * int'(abs_len) + 2);
                for (int i = 0; i < blen; i++)
                    step(1'b1, c, pc, ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)));
                for (int i = 0; i < glen; i++)
                    step(1'b0, CODE_W'($urandom_range(0, 15)), 1'b0,
                         ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule